// File: doc/BRIEF.md
# Flash Write-Completion Status Poller

This block sits on the host side of a parallel flash device. After a program or erase command has been issued, it decides whether the internal operation has finished by reading the written location again and again. A one-cycle start pulse captures three things: the target address, the data expected once the write has finished, and the detection method. The block then issues single read requests over a request/response handshake and inspects each returned word. It ends with exactly one verdict pulse: done, fail (optionally flagged as a timeout), or suspended.

Two detection methods are offered. The first compares the most significant status bit with the expected data, because that bit reads inverted while the operation is still running. The second watches a status bit that flips on every read while the operation is running. Completion can coincide with a status read, so a single read can look like a failure when it is not. When a read appears to conflict with the expected data, the block therefore reads the location exactly twice more before it gives any verdict.

Top module: `flash_status_poller`

## Requirements
- R1: While reset is held and in the first cycle after it, `rd_req_o`, `busy_o`, `done_o`, `fail_o`, `timeout_o` and `suspend_o` are all 0.
- R2: No read request is issued while idle. The first request is issued in the cycle after start is sampled. Each request (`rd_req_o`) lasts one cycle.
- R3: In bit-polarity mode (`toggle_mode_i`=0 at start), a read whose bit 7 differs from bit 7 of the expected data means busy and causes another read. A read whose bit 7 matches and whose whole word equals the expected data gives done.
- R4: In toggle mode (`toggle_mode_i`=1 at start), the first read never ends the operation. A read whose bit 6 equals bit 6 of the previous read and whose whole word equals the expected data gives done. A changed bit 6 means busy.
- R5: A read that shows completion but whose word differs from the expected data starts exactly two confirming reads of the same address. Done is given only if both confirming reads equal the expected data. Otherwise fail is given, and only after the second confirming read.
- R6: In toggle mode, a read that has bit 6 equal to 1 in both this read and the previous one, and whose bit 2 differs from the previous read, gives a suspended pulse with no further reads.
- R7: After MAX_POLLS busy reads, the block gives fail and timeout together in the same cycle and stops reading.
- R8: Done, fail and suspended are one-cycle pulses, at most one of them at a time. `busy_o` is 0 in the cycle the pulse is high, and no request accompanies it.
- R9: Address, expected data and mode are captured at start. Changes to those inputs while busy have no effect, and a start pulse while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle start of a poll session |
| toggle_mode_i | input | 1 | 1 = toggle-bit detection, 0 = bit-polarity detection |
| addr_i | input | AW | Address that was written |
| expect_i | input | DW | Data expected once the write has finished |
| rd_req_o | output | 1 | One-cycle read request |
| rd_addr_o | output | AW | Read address, held for the whole session |
| rd_valid_i | input | 1 | Read data is present |
| rd_data_i | input | DW | Returned read word |
| busy_o | output | 1 | Session in progress |
| done_o | output | 1 | Pulse: write finished |
| fail_o | output | 1 | Pulse: write failed or timed out |
| timeout_o | output | 1 | Pulse with fail_o when the poll limit was reached |
| suspend_o | output | 1 | Pulse: location reads as erase-suspended |

## Verification
The assertions rely on the read port answering each request with exactly one `rd_valid_i` beat. That beat must come at least one cycle after the request and before the next request. A beat that arrives while no read is outstanding is not covered. The bench's device model follows this rule. It records a request at one falling edge and presents data for a single cycle one cycle later, drawing the words from the current vector's script. The bench also changes the captured inputs and pulses start again while a session is running, which tests that these are ignored.

// File: rtl/flash_poll_pkg.sv
package flash_poll_pkg;
  localparam int POLARITY_BIT = 7;
  localparam int TOGGLE_BIT   = 6;
  localparam int SUSPEND_BIT  = 2;

  typedef enum logic [1:0] {
    V_BUSY,
    V_MATCH,
    V_CONFLICT,
    V_SUSPEND
  } verdict_e;

  typedef enum logic [1:0] {
    PH_POLL,
    PH_CONF1,
    PH_CONF2
  } phase_e;

  typedef enum logic {
    S_IDLE,
    S_WAIT
  } state_e;
endpackage

// File: rtl/flash_poll_eval.sv
module flash_poll_eval
  import flash_poll_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          toggle_mode,
  input  logic          have_prev,
  input  logic [DW-1:0] rd_word,
  input  logic [DW-1:0] prev_word,
  input  logic [DW-1:0] expect_word,
  output logic          word_equal,
  output verdict_e      verdict
);
  logic tog_stable;
  logic susp_seen;

  always_comb begin
    word_equal = (rd_word == expect_word);
    tog_stable = have_prev && (rd_word[TOGGLE_BIT] == prev_word[TOGGLE_BIT]);
    susp_seen  = tog_stable && rd_word[TOGGLE_BIT] &&
                 (rd_word[SUSPEND_BIT] != prev_word[SUSPEND_BIT]);
    verdict    = V_BUSY;
    if (!toggle_mode) begin
      if (rd_word[POLARITY_BIT] == expect_word[POLARITY_BIT])
        verdict = word_equal ? V_MATCH : V_CONFLICT;
    end else if (susp_seen) begin
      verdict = V_SUSPEND;
    end else if (tog_stable) begin
      verdict = word_equal ? V_MATCH : V_CONFLICT;
    end
  end
endmodule

// File: rtl/flash_poll_counter.sv
module flash_poll_counter #(
  parameter int MAX_POLLS = 1024
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic inc,
  output logic at_limit
);
  localparam int CW = $clog2(MAX_POLLS + 1);
  localparam logic [CW-1:0] LAST = CW'(MAX_POLLS - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt_q <= '0;
    else if (inc)   cnt_q <= cnt_q + 1'b1;
  end

  assign at_limit = (cnt_q == LAST);
endmodule

// File: rtl/flash_status_poller.sv
module flash_status_poller
  import flash_poll_pkg::*;
#(
  parameter int AW        = 20,
  parameter int DW        = 8,
  parameter int MAX_POLLS = 1024
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic          toggle_mode_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] expect_i,
  output logic          rd_req_o,
  output logic [AW-1:0] rd_addr_o,
  input  logic          rd_valid_i,
  input  logic [DW-1:0] rd_data_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          fail_o,
  output logic          timeout_o,
  output logic          suspend_o
);
  state_e        state_q;
  phase_e        phase_q;
  logic          mode_q;
  logic [DW-1:0] exp_q;
  logic [DW-1:0] prev_q;
  logic          have_prev_q;
  logic          conf_ok_q;
  logic          accept;
  logic          begin_run;
  logic          word_equal;
  logic          at_limit;
  verdict_e      verdict;

  assign begin_run = (state_q == S_IDLE) && start_i;
  assign accept    = (state_q == S_WAIT) && rd_valid_i && !rd_req_o;
  assign busy_o    = (state_q == S_WAIT);

  flash_poll_eval #(.DW(DW)) u_eval (
    .toggle_mode (mode_q),
    .have_prev   (have_prev_q),
    .rd_word     (rd_data_i),
    .prev_word   (prev_q),
    .expect_word (exp_q),
    .word_equal  (word_equal),
    .verdict     (verdict)
  );

  flash_poll_counter #(.MAX_POLLS(MAX_POLLS)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .clr      (begin_run),
    .inc      (accept && (phase_q == PH_POLL) && (verdict == V_BUSY)),
    .at_limit (at_limit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= S_IDLE;
      phase_q     <= PH_POLL;
      mode_q      <= 1'b0;
      exp_q       <= '0;
      prev_q      <= '0;
      have_prev_q <= 1'b0;
      conf_ok_q   <= 1'b0;
      rd_addr_o   <= '0;
      rd_req_o    <= 1'b0;
      done_o      <= 1'b0;
      fail_o      <= 1'b0;
      timeout_o   <= 1'b0;
      suspend_o   <= 1'b0;
    end else begin
      rd_req_o  <= 1'b0;
      done_o    <= 1'b0;
      fail_o    <= 1'b0;
      timeout_o <= 1'b0;
      suspend_o <= 1'b0;
      if (begin_run) begin
        mode_q      <= toggle_mode_i;
        exp_q       <= expect_i;
        rd_addr_o   <= addr_i;
        phase_q     <= PH_POLL;
        have_prev_q <= 1'b0;
        conf_ok_q   <= 1'b0;
        rd_req_o    <= 1'b1;
        state_q     <= S_WAIT;
      end else if (accept) begin
        prev_q      <= rd_data_i;
        have_prev_q <= 1'b1;
        unique case (phase_q)
          PH_POLL: begin
            unique case (verdict)
              V_BUSY: begin
                if (at_limit) begin
                  fail_o    <= 1'b1;
                  timeout_o <= 1'b1;
                  state_q   <= S_IDLE;
                end else begin
                  rd_req_o  <= 1'b1;
                end
              end
              V_MATCH: begin
                done_o  <= 1'b1;
                state_q <= S_IDLE;
              end
              V_CONFLICT: begin
                phase_q  <= PH_CONF1;
                rd_req_o <= 1'b1;
              end
              V_SUSPEND: begin
                suspend_o <= 1'b1;
                state_q   <= S_IDLE;
              end
            endcase
          end
          PH_CONF1: begin
            conf_ok_q <= word_equal;
            phase_q   <= PH_CONF2;
            rd_req_o  <= 1'b1;
          end
          default: begin
            if (conf_ok_q && word_equal) done_o <= 1'b1;
            else                         fail_o <= 1'b1;
            state_q <= S_IDLE;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/flash_poll_checker.sv
module flash_poll_checker #(
  parameter int AW = 20
) (
  input logic          clk,
  input logic          rst,
  input logic          rd_req_o,
  input logic [AW-1:0] rd_addr_o,
  input logic          busy_o,
  input logic          done_o,
  input logic          fail_o,
  input logic          timeout_o,
  input logic          suspend_o
);
  logic any_end;
  assign any_end = done_o || fail_o || suspend_o;

  assert_req_one_cycle_R2: assert property (@(posedge clk) disable iff (rst)
    rd_req_o |=> !rd_req_o);

  assert_req_only_busy_R2: assert property (@(posedge clk) disable iff (rst)
    rd_req_o |-> busy_o);

  assert_first_req_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> rd_req_o);

  assert_one_verdict_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0({done_o, fail_o, suspend_o}));

  assert_verdict_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    any_end |=> !(done_o || fail_o || suspend_o));

  assert_verdict_idle_R8: assert property (@(posedge clk) disable iff (rst)
    any_end |-> (!busy_o && !rd_req_o));

  assert_timeout_fail_R7: assert property (@(posedge clk) disable iff (rst)
    timeout_o |-> fail_o);

  assert_addr_held_R9: assert property (@(posedge clk) disable iff (rst)
    (busy_o && $past(busy_o)) |-> $stable(rd_addr_o));
endmodule

bind flash_status_poller flash_poll_checker #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .rd_req_o  (rd_req_o),
  .rd_addr_o (rd_addr_o),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .fail_o    (fail_o),
  .timeout_o (timeout_o),
  .suspend_o (suspend_o)
);

// File: tb/test_flash_status_poller.sv
`timescale 1ns/1ps
module test_flash_status_poller;
  localparam int AW = 20;
  localparam int DW = 8;
  localparam int MAXP = 6;

  typedef struct packed {
    logic        tgl;
    logic [7:0]  exp;
    logic [63:0] rds;  // read k returns byte k (byte 0 = lowest)
    logic [3:0]  nrd;
    logic [1:0]  res;  // 0 done, 1 fail, 2 timeout, 3 suspended
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{1'b0, 8'hA5, 64'h0000_0000_00A5_2525, 4'd3, 2'd0},
    '{1'b0, 8'hA5, 64'h0000_0000_00A5_A580, 4'd3, 2'd0},
    '{1'b0, 8'hA5, 64'h0000_0000_0080_A580, 4'd3, 2'd1},
    '{1'b0, 8'hA5, 64'h2525_2525_2525_2525, 4'd6, 2'd2},
    '{1'b1, 8'hA5, 64'h0000_00A5_A540_0040, 4'd5, 2'd0},
    '{1'b1, 8'hA5, 64'h0000_0000_0000_4044, 4'd2, 2'd3},
    '{1'b1, 8'hA5, 64'h0000_0000_11A5_1111, 4'd4, 2'd1},
    '{1'b1, 8'hA5, 64'h0040_0040_0040_0040, 4'd6, 2'd2}
  };
  localparam string TAGS [8] = '{"R3", "R5", "R5", "R7", "R4", "R6", "R5", "R7"};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0;
  logic toggle_mode_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [DW-1:0] expect_i = '0;
  logic rd_valid_i;
  logic [DW-1:0] rd_data_i;
  logic rd_req_o, busy_o, done_o, fail_o, timeout_o, suspend_o;
  logic [AW-1:0] rd_addr_o;

  int checks = 0;
  int errors = 0;
  int nreads = 0;
  int cycles = 0;
  logic [63:0] cur_rd = '0;

  always #4 clk = ~clk;

  flash_status_poller #(.AW(AW), .DW(DW), .MAX_POLLS(MAXP)) i_flash_status_poller (
    .clk(clk), .rst(rst), .start_i(start_i), .toggle_mode_i(toggle_mode_i),
    .addr_i(addr_i), .expect_i(expect_i), .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o),
    .rd_valid_i(rd_valid_i), .rd_data_i(rd_data_i), .busy_o(busy_o), .done_o(done_o),
    .fail_o(fail_o), .timeout_o(timeout_o), .suspend_o(suspend_o)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  // device model: answers each request once, one cycle later
  initial begin
    bit pend = 0;
    rd_valid_i = 1'b0;
    rd_data_i  = '0;
    forever begin
      @(negedge clk);
      if (rd_valid_i) rd_valid_i = 1'b0;
      else if (pend) begin
        rd_valid_i = 1'b1;
        rd_data_i  = cur_rd[((nreads > 7) ? 7 : nreads) * 8 +: 8];
        nreads++;
        pend = 0;
      end
      if (rd_req_o) pend = 1;
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        errors++;
        checks++;
        $display("FAIL watchdog R8 actual %0d expected %0d", cycles, 20000);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  function automatic logic [2:0] outcome();
    if (done_o && !fail_o && !suspend_o) return 3'd0;
    if (fail_o && !timeout_o && !done_o && !suspend_o) return 3'd1;
    if (fail_o && timeout_o && !done_o && !suspend_o) return 3'd2;
    if (suspend_o && !done_o && !fail_o) return 3'd3;
    return 3'd7;
  endfunction

  task automatic wait_end(output logic [2:0] code);
    code = 3'd6;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (done_o || fail_o || suspend_o) begin
        code = outcome();
        break;
      end
    end
  endtask

  task automatic run_vec(input vec_t v, input string tag, input logic [AW-1:0] a);
    logic [2:0] code;
    int seen;
    cur_rd = v.rds;
    nreads = 0;
    @(negedge clk);
    addr_i = a; expect_i = v.exp; toggle_mode_i = v.tgl; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    // R9: scramble captured inputs while busy
    addr_i = ~a; expect_i = ~v.exp; toggle_mode_i = ~v.tgl;
    chk(rd_req_o == 1'b1, "R2 first request", rd_req_o, 1);
    chk(rd_addr_o == a, "R9 address captured", rd_addr_o, a);
    wait_end(code);
    seen = nreads;
    chk(code == {1'b0, v.res}, {tag, " verdict"}, code, v.res);
    chk(seen == v.nrd, {tag, " read count"}, seen, v.nrd);
    @(negedge clk);
    chk(!(done_o || fail_o || suspend_o || busy_o || rd_req_o), "R8 pulse ends",
        {done_o, fail_o, suspend_o, busy_o, rd_req_o}, 0);
    @(negedge clk);
    chk(nreads == seen, "R8 no read after verdict", nreads, seen);
  endtask

  initial begin
    logic [2:0] code;
    repeat (3) @(negedge clk);
    chk({rd_req_o, busy_o, done_o, fail_o, timeout_o, suspend_o} == 6'b0, "R1 in reset",
        {rd_req_o, busy_o, done_o, fail_o, timeout_o, suspend_o}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk({rd_req_o, busy_o, done_o, fail_o, timeout_o, suspend_o} == 6'b0, "R1 after reset",
        {rd_req_o, busy_o, done_o, fail_o, timeout_o, suspend_o}, 0);
    repeat (4) @(negedge clk);
    chk(rd_req_o == 1'b0 && nreads == 0, "R2 idle without requests", nreads, 0);

    for (int i = 0; i < 8; i++) run_vec(VECS[i], TAGS[i], AW'(20'h1_2340 + i));

    // R9: second start while busy is ignored
    cur_rd = VECS[0].rds;
    nreads = 0;
    @(negedge clk);
    addr_i = 20'h0_0AAA; expect_i = 8'hA5; toggle_mode_i = 1'b0; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    @(negedge clk);
    addr_i = 20'h0_03C3; expect_i = 8'h25; toggle_mode_i = 1'b1; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    wait_end(code);
    chk(code == 3'd0, "R9 start while busy verdict", code, 0);
    chk(nreads == 3, "R9 start while busy reads", nreads, 3);
    chk(rd_addr_o == 20'h0_0AAA, "R9 start while busy address", rd_addr_o, 20'h0_0AAA);
    repeat (3) @(negedge clk);
    chk(!busy_o && nreads == 3, "R9 no restart", nreads, 3);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule